// File: doc/BRIEF.md
# Degradable-Width Flit Lane Serializer

This block carries fixed 80-bit link flits across a lane group that can shrink when lanes fail. On the transmit side a flit is formed from a 64-bit payload, an 8-bit link header and a CRC-8 check byte. The flit is then cut into lane-wide beats. On the receive side the beats are gathered back into a flit, and the check byte is recomputed and compared.

The 20 data lanes are organised as four quadrants of five lanes each. A four-bit quadrant mask selects which quadrants carry data. Four active quadrants give full width, two give half width and one gives quarter width. Double-data-rate beats are modelled as two beats per clock. The lane bus is therefore 40 bits wide, with lanes 19..0 as the first beat and lanes 39..20 as the second. The flit format is the same at every width; only the number of cycles per flit changes.

Both directions sample the mask only at a flit boundary, so the two ends of a link stay in step when the mask is changed.

Top module: `flit_lane_serdes`

## Requirements
- R1: The transmitted flit is {check[79:72], header[71:64], payload[63:0]}. The check byte is a CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value zero, no reflection and no final inversion, computed over the 72-bit value {header, payload} starting from its most significant bit.
- R2: With all four quadrants active, a flit takes 2 cycles. In cycle c, txLanes[19:0] carries flit bits [40c+19:40c] and txLanes[39:20] carries bits [40c+39:40c+20].
- R3: With n active quadrants (n = 1 or 2), the slice width is W=5n and a flit takes 8/n cycles. Beat b of cycle c carries slice s=2c+b, which is flit bits [sW+W-1:sW]. Within a slice, the j-th active quadrant in ascending index takes bits 5j..5j+4 on its five lanes, lowest lane first. Lanes of inactive quadrants are zero.
- R4: A mask with zero or three bits set is treated as 4'b0001, which means quarter width on quadrant 0.
- R5: txReady is high when no flit is in flight and during the last cycle of a flit, and low in every other cycle. A flit accepted on a clock edge drives its first cycle right after that edge, so flits can follow each other with no gap.
- R6: txLaneValid is high exactly during the cycles of a flit. When no flit is in flight, txLanes is all zero.
- R7: The transmitter samples the mask when it accepts a flit. The receiver samples the mask on the first valid beat of a flit. A mask change in the middle of a flit does not affect that flit.
- R8: After the last beat of a flit, rxFlitValid pulses high for one cycle, and rxHeader and rxPayload hold the reassembled fields during that cycle.
- R9: If the received check byte differs from the CRC recomputed over the received header and payload, rxCrcErr is high together with rxFlitValid. The flit is still delivered.
- R10: Cycles with rxLaneValid low do not advance reassembly and do not change it.
- R11: After reset, txReady is 1, txLaneValid is 0, txLanes is 0 and rxFlitValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgQuadMask | input | 4 | Active quadrant mask, sampled at flit boundaries |
| txValid | input | 1 | Transmit flit offered |
| txReady | output | 1 | Transmit flit can be accepted |
| txPayload | input | 64 | Transmit payload |
| txHeader | input | 8 | Transmit link header |
| txLanes | output | 40 | Two lane beats per cycle, first beat in bits 19..0 |
| txLaneValid | output | 1 | txLanes carries flit data |
| rxLanes | input | 40 | Received two-beat lane word |
| rxLaneValid | input | 1 | rxLanes carries flit data this cycle |
| rxFlitValid | output | 1 | Reassembled flit available |
| rxPayload | output | 64 | Received payload |
| rxHeader | output | 8 | Received link header |
| rxCrcErr | output | 1 | Check byte mismatch on the delivered flit |

## Verification
The bench builds the block with its default geometry: four quadrants of five lanes and an 80-bit flit. With that geometry, the 2-, 4- and 8-cycle flit lengths can all be reached, as can every quadrant placement, including masks with a gap such as 4'b1010 and the fallback masks. Transmit is looped back into receive, so mask changes in the middle of a flit are seen by both ends. Single-bit corruption is injected on the lowest active lane. Receive gaps are driven directly on the receive port.

// File: rtl/flit_lane_pkg.sv
package flit_lane_pkg;
  localparam int PAY_W      = 64;
  localparam int HDR_W      = 8;
  localparam int CRC_W      = 8;
  localparam int QUAD_LANES = 5;
  localparam int NUM_QUADS  = 4;
  localparam int BODY_W     = PAY_W + HDR_W;
  localparam int FLIT_W     = BODY_W + CRC_W;
  localparam int LANE_W     = NUM_QUADS * QUAD_LANES;
  localparam int DBL_W      = 2 * LANE_W;
  localparam int CNT_W      = $clog2(FLIT_W / (2 * QUAD_LANES));
  localparam int IDX_W      = $clog2(FLIT_W);
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  typedef struct packed {
    logic                 txLoad;
    logic                 txBusy;
    logic [CNT_W-1:0]     txCnt;
    logic [NUM_QUADS-1:0] txMask;
    logic                 rxStore;
    logic [CNT_W-1:0]     rxCnt;
    logic [NUM_QUADS-1:0] rxMask;
    logic                 rxDone;
  } ctrl_t;

  function automatic logic [NUM_QUADS-1:0] legalMask(input logic [NUM_QUADS-1:0] m);
    int cnt;
    cnt = $countones(m);
    if (cnt == 1 || cnt == 2 || cnt == NUM_QUADS) return m;
    return NUM_QUADS'(1);
  endfunction

  function automatic int cyclesFor(input logic [NUM_QUADS-1:0] m);
    return FLIT_W / (2 * QUAD_LANES * $countones(m));
  endfunction

  function automatic logic [CRC_W-1:0] crcCalc(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ body[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  // flit bit carried by lane (quad, lane) of beat 'beat' in cycle 'cnt'
  function automatic logic [IDX_W-1:0] slotIndex(input logic [NUM_QUADS-1:0] m,
                                                 input logic [CNT_W-1:0] cnt,
                                                 input int beat, input int quad,
                                                 input int lane);
    int rank;
    int w;
    int pos;
    rank = 0;
    for (int k = 0; k < NUM_QUADS; k++)
      if (k < quad) rank += int'(m[k]);
    w   = QUAD_LANES * $countones(m);
    pos = (2 * int'(cnt) + beat) * w + rank * QUAD_LANES + lane;
    return pos[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/flit_lane_ctrl.sv
module flit_lane_ctrl
  import flit_lane_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_QUADS-1:0] cfgQuadMask,
  input  logic                 txValid,
  input  logic                 rxLaneValid,
  output logic                 txReady,
  output logic                 txLaneValid,
  output ctrl_t                ctl
);
  logic                 txBusy;
  logic [CNT_W-1:0]     txCnt;
  logic [NUM_QUADS-1:0] txMaskQ;
  logic [CNT_W-1:0]     rxCnt;
  logic [NUM_QUADS-1:0] rxMaskQ;
  logic                 rxDoneQ;
  logic [NUM_QUADS-1:0] cfgLegal;
  logic [NUM_QUADS-1:0] rxMaskNow;
  logic                 txLast;
  logic                 txAccept;
  logic                 rxLast;

  assign cfgLegal  = legalMask(cfgQuadMask);
  assign txLast    = txBusy && (int'(txCnt) == cyclesFor(txMaskQ) - 1);
  assign txReady   = !txBusy || txLast;
  assign txAccept  = txValid && txReady;
  assign rxMaskNow = (rxCnt == '0) ? cfgLegal : rxMaskQ;
  assign rxLast    = rxLaneValid && (int'(rxCnt) == cyclesFor(rxMaskNow) - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txCnt   <= '0;
      txMaskQ <= '1;
    end else if (txAccept) begin
      txBusy  <= 1'b1;
      txCnt   <= '0;
      txMaskQ <= cfgLegal;
    end else if (txLast) begin
      txBusy  <= 1'b0;
      txCnt   <= '0;
    end else if (txBusy) begin
      txCnt   <= txCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt   <= '0;
      rxMaskQ <= '1;
      rxDoneQ <= 1'b0;
    end else begin
      rxDoneQ <= rxLast;
      if (rxLaneValid) begin
        if (rxCnt == '0) rxMaskQ <= cfgLegal;
        rxCnt <= rxLast ? '0 : rxCnt + 1'b1;
      end
    end
  end

  assign txLaneValid = txBusy;
  always_comb begin
    ctl.txLoad  = txAccept;
    ctl.txBusy  = txBusy;
    ctl.txCnt   = txCnt;
    ctl.txMask  = txMaskQ;
    ctl.rxStore = rxLaneValid;
    ctl.rxCnt   = rxCnt;
    ctl.rxMask  = rxMaskNow;
    ctl.rxDone  = rxDoneQ;
  end

  AST_TX_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !txLast) |=> $stable(txMaskQ)); // R7
  AST_TX_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> ($countones(txMaskQ) == 1 || $countones(txMaskQ) == 2 || $countones(txMaskQ) == NUM_QUADS)); // R4
  AST_TX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> (int'(txCnt) < cyclesFor(txMaskQ))); // R3
  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneQ |=> !rxDoneQ); // R8
  AST_RX_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxCnt != '0) |=> $stable(rxMaskQ)); // R7
endmodule

// File: rtl/flit_lane_datapath.sv
module flit_lane_datapath
  import flit_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [PAY_W-1:0]  txPayload,
  input  logic [HDR_W-1:0]  txHeader,
  input  logic [DBL_W-1:0]  rxLanes,
  output logic [DBL_W-1:0]  txLanes,
  output logic [PAY_W-1:0]  rxPayload,
  output logic [HDR_W-1:0]  rxHeader,
  output logic              rxCrcErr
);
  logic [FLIT_W-1:0] txFlit;
  logic [FLIT_W-1:0] rxFlit;
  logic [FLIT_W-1:0] rxFlitNext;

  always_ff @(posedge clk) begin
    if (!rstN) txFlit <= '0;
    else if (ctl.txLoad) txFlit <= {crcCalc({txHeader, txPayload}), txHeader, txPayload};
  end

  always_comb begin
    txLanes    = '0;
    rxFlitNext = rxFlit;
    for (int b = 0; b < 2; b++) begin
      for (int q = 0; q < NUM_QUADS; q++) begin
        for (int l = 0; l < QUAD_LANES; l++) begin
          if (ctl.txBusy && ctl.txMask[q])
            txLanes[b*LANE_W + q*QUAD_LANES + l] = txFlit[slotIndex(ctl.txMask, ctl.txCnt, b, q, l)];
          if (ctl.rxStore && ctl.rxMask[q])
            rxFlitNext[slotIndex(ctl.rxMask, ctl.rxCnt, b, q, l)] = rxLanes[b*LANE_W + q*QUAD_LANES + l];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxFlit <= '0;
    else if (ctl.rxStore) rxFlit <= rxFlitNext;
  end

  assign rxPayload = rxFlit[PAY_W-1:0];
  assign rxHeader  = rxFlit[BODY_W-1:PAY_W];
  assign rxCrcErr  = ctl.rxDone && (crcCalc(rxFlit[BODY_W-1:0]) != rxFlit[FLIT_W-1:BODY_W]);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.txBusy |-> (txLanes == '0)); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rxCrcErr |-> ctl.rxDone); // R9
endmodule

// File: rtl/flit_lane_serdes.sv
module flit_lane_serdes
  import flit_lane_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_QUADS-1:0] cfgQuadMask,
  input  logic                 txValid,
  output logic                 txReady,
  input  logic [PAY_W-1:0]     txPayload,
  input  logic [HDR_W-1:0]     txHeader,
  output logic [DBL_W-1:0]     txLanes,
  output logic                 txLaneValid,
  input  logic [DBL_W-1:0]     rxLanes,
  input  logic                 rxLaneValid,
  output logic                 rxFlitValid,
  output logic [PAY_W-1:0]     rxPayload,
  output logic [HDR_W-1:0]     rxHeader,
  output logic                 rxCrcErr
);
  ctrl_t ctl;

  flit_lane_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgQuadMask(cfgQuadMask), .txValid(txValid),
    .rxLaneValid(rxLaneValid), .txReady(txReady), .txLaneValid(txLaneValid), .ctl(ctl)
  );

  flit_lane_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txPayload(txPayload), .txHeader(txHeader),
    .rxLanes(rxLanes), .txLanes(txLanes), .rxPayload(rxPayload), .rxHeader(rxHeader),
    .rxCrcErr(rxCrcErr)
  );

  assign rxFlitValid = ctl.rxDone;
endmodule

// File: tb/sim_flit_lane_serdes.sv
module sim_flit_lane_serdes;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgQuadMask = 4'hF;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [63:0] txPayload = '0;
  logic [7:0]  txHeader = '0;
  logic [39:0] txLanes;
  logic        txLaneValid;
  logic [39:0] rxLanes;
  logic        rxLaneValid;
  logic        rxFlitValid;
  logic [63:0] rxPayload;
  logic [7:0]  rxHeader;
  logic        rxCrcErr;

  logic        loopEn = 1'b1;
  logic [39:0] corrupt = '0;
  logic [39:0] rxDrv = '0;
  logic        rxValidDrv = 1'b0;

  int tests = 0;
  int failed = 0;
  int wr = 0;
  int rd = 0;
  logic [7:0]  expHdr [256];
  logic [63:0] expPay [256];
  logic        expErr [256];

  always #4 clk = ~clk;

  assign rxLanes     = loopEn ? (txLanes ^ corrupt) : rxDrv;
  assign rxLaneValid = loopEn ? txLaneValid : rxValidDrv;

  flit_lane_serdes u0 (
    .clk(clk), .rstN(rstN), .cfgQuadMask(cfgQuadMask), .txValid(txValid), .txReady(txReady),
    .txPayload(txPayload), .txHeader(txHeader), .txLanes(txLanes), .txLaneValid(txLaneValid),
    .rxLanes(rxLanes), .rxLaneValid(rxLaneValid), .rxFlitValid(rxFlitValid),
    .rxPayload(rxPayload), .rxHeader(rxHeader), .rxCrcErr(rxCrcErr)
  );

  function automatic logic [7:0] bCrc(input logic [71:0] v);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 71; i >= 0; i--) begin
      if (c[7] ^ v[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [3:0] bEff(input logic [3:0] m);
    int c;
    c = $countones(m);
    return (c == 1 || c == 2 || c == 4) ? m : 4'b0001;
  endfunction

  function automatic int bCycles(input logic [3:0] m);
    return 8 / $countones(m);
  endfunction

  function automatic int bFirst(input logic [3:0] m);
    for (int q = 3; q >= 0; q--) if (m[q] && (m & ((4'b1 << q) - 4'b1)) == 4'b0) return q;
    return 0;
  endfunction

  function automatic logic [39:0] bLanes(input logic [79:0] f, input logic [3:0] m, input int cyc);
    logic [39:0] r;
    int act[4];
    int n;
    int w;
    r = '0;
    n = 0;
    for (int q = 0; q < 4; q++) if (m[q]) begin act[n] = q; n++; end
    w = 5 * n;
    for (int b = 0; b < 2; b++)
      for (int j = 0; j < n; j++)
        for (int l = 0; l < 5; l++)
          r[b*20 + act[j]*5 + l] = f[(2*cyc + b)*w + 5*j + l];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && rxFlitValid) begin
      if (expErr[rd % 256]) begin
        check(rxCrcErr == 1'b1, "R9 crc error flag", 80'(rxCrcErr), 80'(1));
        check(rxPayload == expPay[rd % 256], "R9 corrupted flit delivered", 80'(rxPayload), 80'(expPay[rd % 256]));
      end else begin
        check(rxCrcErr == 1'b0, "R8 crc clean", 80'(rxCrcErr), 80'(0));
        check(rxPayload == expPay[rd % 256], "R8 payload", 80'(rxPayload), 80'(expPay[rd % 256]));
      end
      check(rxHeader == expHdr[rd % 256], "R8 header", 80'(rxHeader), 80'(expHdr[rd % 256]));
      rd++;
    end
  end

  // called at a negedge; returns at the negedge of the flit's last cycle
  task automatic sendFlit(input logic [3:0] mask, input logic [7:0] hdr, input logic [63:0] pay,
                          input bit corrupt0, input bit scramble);
    logic [79:0] f;
    logic [3:0]  em;
    int          n;
    string       tag;
    em  = bEff(mask);
    n   = bCycles(em);
    f   = {bCrc({hdr, pay}), hdr, pay};
    tag = scramble ? "R7" : (em != mask) ? "R4" : (n == 2) ? "R2" : "R3";
    check(txReady == 1'b1, "R5 ready at boundary", 80'(txReady), 80'(1));
    cfgQuadMask = mask;
    txValid     = 1'b1;
    txHeader    = hdr;
    txPayload   = pay;
    expHdr[wr % 256] = hdr;
    expPay[wr % 256] = corrupt0 ? (pay ^ 64'd1) : pay;
    expErr[wr % 256] = corrupt0;
    wr++;
    @(negedge clk);
    txValid   = 1'b0;
    txPayload = {$urandom, $urandom};
    txHeader  = 8'($urandom);
    for (int c = 0; c < n; c++) begin
      corrupt = (c == 0 && corrupt0) ? (40'd1 << (bFirst(em) * 5)) : 40'd0;
      check(txLaneValid == 1'b1, "R6 lane valid in flit", 80'(txLaneValid), 80'(1));
      check(txLanes == bLanes(f, em, c), tag, 80'(txLanes), 80'(bLanes(f, em, c)));
      check(txReady == (c == n - 1), "R5 ready timing", 80'(txReady), 80'(c == n - 1));
      if (n == 2 && c == 1)
        check(txLanes[39:32] == bCrc({hdr, pay}), "R1 check byte", 80'(txLanes[39:32]), 80'(bCrc({hdr, pay})));
      if (c == 1 && scramble) cfgQuadMask = 4'($urandom);
      if (c < n - 1) @(negedge clk);
    end
  endtask

  task automatic idle(input int k);
    txValid = 1'b0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      corrupt = '0;
      check(txLaneValid == 1'b0 && txLanes == '0, "R6 idle lanes", {39'd0, txLaneValid, txLanes}, 80'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [79:0] g;
    int seedSink;
    seedSink = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txReady == 1'b1, "R11 reset ready", 80'(txReady), 80'(1));
    check(txLaneValid == 1'b0 && txLanes == '0, "R11 reset lanes", 80'(txLanes), 80'(0));
    check(rxFlitValid == 1'b0, "R11 reset rx valid", 80'(rxFlitValid), 80'(0));

    sendFlit(4'hF, 8'hA5, 64'h0123_4567_89AB_CDEF, 0, 0);
    sendFlit(4'b0011, 8'h3C, 64'hFEDC_BA98_7654_3210, 0, 0);
    sendFlit(4'b1010, 8'h5A, 64'hDEAD_BEEF_CAFE_F00D, 0, 0);
    sendFlit(4'b0100, 8'h01, 64'h8000_0000_0000_0001, 0, 0);
    sendFlit(4'b1000, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    sendFlit(4'b0000, 8'h77, 64'h1111_2222_3333_4444, 0, 0);
    sendFlit(4'b0111, 8'h88, 64'h5555_6666_7777_8888, 0, 0);
    idle(2);
    sendFlit(4'hF, 8'h12, 64'h0F0F_0F0F_0F0F_0F0F, 1, 0);
    sendFlit(4'b0110, 8'h34, 64'h1357_9BDF_2468_ACE0, 1, 0);
    sendFlit(4'b1000, 8'h56, 64'hA5A5_5A5A_A5A5_5A5A, 1, 0);
    sendFlit(4'b0101, 8'h9A, 64'h0000_0000_FFFF_0000, 0, 1);
    sendFlit(4'hF, 8'hBC, 64'h7777_0000_7777_0000, 0, 0);
    idle(3);

    // receive gaps: full width, beat-cycle 0, gap, beat-cycle 1
    loopEn = 1'b0;
    g = {bCrc({8'hC3, 64'h0102_0304_0506_0708}), 8'hC3, 64'h0102_0304_0506_0708};
    cfgQuadMask = 4'hF;
    expHdr[wr % 256] = 8'hC3;
    expPay[wr % 256] = 64'h0102_0304_0506_0708;
    expErr[wr % 256] = 1'b0;
    wr++;
    rxValidDrv = 1'b1; rxDrv = bLanes(g, 4'hF, 0);
    @(negedge clk);
    rxValidDrv = 1'b0; rxDrv = {8'($urandom), $urandom};
    @(negedge clk);
    check(rxFlitValid == 1'b0, "R10 gap ignored", 80'(rxFlitValid), 80'(0));
    rxValidDrv = 1'b1; rxDrv = bLanes(g, 4'hF, 1);
    @(negedge clk);
    rxValidDrv = 1'b0;
    check(rxFlitValid == 1'b1, "R10 flit after gap", 80'(rxFlitValid), 80'(1));
    @(negedge clk);
    loopEn = 1'b1;

    for (int i = 0; i < 150; i++) begin
      sendFlit(4'($urandom), 8'($urandom), {$urandom, $urandom},
               ($urandom % 8) == 0, ($urandom % 4) == 0);
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
    end
    idle(3);
    check(rd == wr, "R8 all flits delivered", 80'(rd), 80'(wr));
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule